// File: doc/BRIEF.md
# Banked Pin I/O Controller with Masked Output Writes

This block is a register-mapped general-purpose I/O controller for 128 pins, organised as four banks of 32. For each bank, software programs a direction register and an output-enable register. It reads back the live pin levels through a read-only input register. Output values are written through eight half-bank registers. Each of these carries a per-pin write-protect mask beside the new values, so one pin or any subset of pins can be changed in a single write without disturbing its neighbours. No read-modify-write sequence is needed.

The register port is a single-cycle strobe interface with a 12-bit byte address, and read data comes back one cycle after the strobe. On the pad side, the block presents an output value vector, an output-enable vector, and an input vector. The input vector passes through a two-stage synchronizer before it can be read.

Top module: `pin_bank_io`

## Requirements
- R1: After reset, every direction, output-enable and output latch bit is 0, so gpio_o, gpio_oe_o and rdata_o are all zero.
- R2: A write to byte address 4*h (h = 0..7) updates the output latches of pins 16*h+j for j = 0..15. wdata bit 16+j is a protect bit for pin 16*h+j: the latch takes wdata bit j where that protect bit is 0, and keeps its old value where it is 1.
- R3: A read of byte address 4*h (h = 0..7) returns the latches of pins 16*h..16*h+15 in bits 15:0 and zero in bits 31:16.
- R4: The direction register of bank b sits at byte address 0x204 + 0x40*b. Bit k belongs to pin 32*b+k, where 1 means output. It is written in full and reads back its stored value.
- R5: The output-enable register of bank b sits at byte address 0x208 + 0x40*b. Bit k belongs to pin 32*b+k. It is written in full and reads back its stored value.
- R6: gpio_oe_o[p] is 1 exactly when both the direction bit and the output-enable bit of pin p are 1. gpio_o[p] always shows the latch of pin p.
- R7: A read of byte address 0x060 + 4*b returns gpio_i[32*b+31:32*b], taken through two synchronizer stages. A level held on gpio_i for three clock edges before the read strobe edge is returned.
- R8: A write to an input-register address, or to any unmapped address, changes no latch, direction or output-enable bit.
- R9: A read of an unmapped address returns zero.
- R10: rdata_o is registered. It carries the read result in the cycle after a read strobe and is zero after any cycle without a read strobe, including write cycles.
- R11: Address bits 1:0 are ignored, and decoding uses the word address only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| gpio_i | input | 128 | Pad input levels |
| gpio_o | output | 128 | Pad output values |
| gpio_oe_o | output | 128 | Pad output enables |

## Verification
Register writes take effect on the strobe edge, so gpio_o and gpio_oe_o are compared at the falling edge that follows it. Read data is registered on the strobe edge and sampled at the next falling edge. Pin levels need two synchronizer edges and then the read edge, so the bench holds a new gpio_i value for three full cycles before it issues the input-register read. Every expected value is produced by bench functions that model the latch, direction and enable state from the written values, and random traffic is mixed with directed protect-mask, unmapped and read-only cases.

// File: rtl/pbio_pkg.sv
package pbio_pkg;
  localparam int PB_NUM_BANKS   = 4;
  localparam int PB_BANK_W      = 32;
  localparam int PB_HALF_W      = 16;
  localparam int PB_ADDR_W      = 12;
  localparam int PB_DATA_W      = 32;
  localparam int PB_MDATA_BASE  = 'h000;
  localparam int PB_IN_BASE     = 'h060;
  localparam int PB_DIR_BASE    = 'h204;
  localparam int PB_OE_BASE     = 'h208;
  localparam int PB_BANK_STRIDE = 'h040;
endpackage

// File: rtl/pbio_sync.sv
module pbio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pbio_bank.sv
module pbio_bank import pbio_pkg::*; #(
  parameter int BANK_IDX = 0,
  parameter int BANK_W   = PB_BANK_W,
  parameter int HALF_W   = PB_HALF_W,
  parameter int ADDR_W   = PB_ADDR_W,
  parameter int DATA_W   = PB_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] pin_sync_i,
  output logic [BANK_W-1:0] out_val_o,
  output logic [BANK_W-1:0] out_en_o,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int HALVES = BANK_W / HALF_W;
  localparam int WA_W   = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(PB_DIR_BASE + PB_BANK_STRIDE * BANK_IDX);
  localparam logic [ADDR_W-1:0] OE_A  = ADDR_W'(PB_OE_BASE + PB_BANK_STRIDE * BANK_IDX);
  localparam logic [ADDR_W-1:0] IN_A  = ADDR_W'(PB_IN_BASE + 4 * BANK_IDX);

  logic [WA_W-1:0]   word;
  logic              wr, rd;
  logic [BANK_W-1:0] dir_q, oe_q, lat_q;
  logic              dir_hit, oe_hit, in_hit;
  logic [HALVES-1:0] half_hit;

  assign word    = addr_i[ADDR_W-1:2];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign dir_hit = word == DIR_A[ADDR_W-1:2];
  assign oe_hit  = word == OE_A[ADDR_W-1:2];
  assign in_hit  = word == IN_A[ADDR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      oe_q  <= '0;
    end else begin
      if (wr && dir_hit) dir_q <= wdata_i[BANK_W-1:0];
      if (wr && oe_hit)  oe_q  <= wdata_i[BANK_W-1:0];
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] MD_A =
      ADDR_W'(PB_MDATA_BASE + 4 * (BANK_IDX * HALVES + h));
    logic [HALF_W-1:0] prot;
    assign half_hit[h] = word == MD_A[ADDR_W-1:2];
    assign prot        = wdata_i[HALF_W +: HALF_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_q[h*HALF_W +: HALF_W] <= '0;
      end else if (wr && half_hit[h]) begin
        // protected bits keep their value, the rest load new data
        lat_q[h*HALF_W +: HALF_W] <= (lat_q[h*HALF_W +: HALF_W] & prot)
                                   | (wdata_i[HALF_W-1:0] & ~prot);
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_hit_o  = rd && (dir_hit || oe_hit || in_hit || (|half_hit));
    if (dir_hit)     rd_data_o = DATA_W'(dir_q);
    else if (oe_hit) rd_data_o = DATA_W'(oe_q);
    else if (in_hit) rd_data_o = DATA_W'(pin_sync_i);
    else begin
      for (int h = 0; h < HALVES; h++)
        if (half_hit[h]) rd_data_o = DATA_W'(lat_q[h*HALF_W +: HALF_W]);
    end
  end

  assign out_val_o = lat_q;
  assign out_en_o  = dir_q & oe_q;
endmodule

// File: rtl/pbio_rdmux.sv
module pbio_rdmux #(
  parameter int N      = 4,
  parameter int DATA_W = 32
) (
  input  logic [N-1:0]        hit_i,
  input  logic [N*DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]   data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_i[i]) data_o = data_o | data_i[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/pin_bank_io.sv
module pin_bank_io import pbio_pkg::*; #(
  parameter int NUM_BANKS = PB_NUM_BANKS,
  parameter int BANK_W    = PB_BANK_W,
  parameter int HALF_W    = PB_HALF_W,
  parameter int ADDR_W    = PB_ADDR_W,
  parameter int DATA_W    = PB_DATA_W,
  localparam int NUM_PINS = NUM_BANKS * BANK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o
);
  logic [NUM_PINS-1:0]         pin_sync;
  logic [NUM_BANKS-1:0]        bank_hit;
  logic [NUM_BANKS*DATA_W-1:0] bank_data;
  logic [DATA_W-1:0]           rd_mux;

  pbio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pbio_bank #(
      .BANK_IDX(b),
      .BANK_W  (BANK_W),
      .HALF_W  (HALF_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i),
      .we_i      (we_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .pin_sync_i(pin_sync[b*BANK_W +: BANK_W]),
      .out_val_o (gpio_o[b*BANK_W +: BANK_W]),
      .out_en_o  (gpio_oe_o[b*BANK_W +: BANK_W]),
      .rd_hit_o  (bank_hit[b]),
      .rd_data_o (bank_data[b*DATA_W +: DATA_W])
    );
  end

  pbio_rdmux #(.N(NUM_BANKS), .DATA_W(DATA_W)) u_rdmux (
    .hit_i (bank_hit),
    .data_i(bank_data),
    .data_o(rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd_mux;
    else                       rdata_o <= '0;
  end
endmodule

// File: rtl/pbio_chk.sv
module pbio_chk import pbio_pkg::*; #(
  localparam int NUM_PINS = PB_NUM_BANKS * PB_BANK_W,
  localparam int N_HALF   = NUM_PINS / PB_HALF_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [PB_ADDR_W-1:0] addr_i,
  input logic [PB_DATA_W-1:0] wdata_i,
  input logic [PB_DATA_W-1:0] rdata_o,
  input logic [NUM_PINS-1:0]  gpio_i,
  input logic [NUM_PINS-1:0]  gpio_o,
  input logic [NUM_PINS-1:0]  gpio_oe_o
);
  logic [PB_ADDR_W-3:0] word;
  logic                 wr_md, wr_in;
  logic [NUM_PINS-1:0]  keep, newv;

  assign word  = addr_i[PB_ADDR_W-1:2];
  assign wr_md = req_i && we_i && (int'(word) < N_HALF);
  assign wr_in = req_i && we_i && (int'(word) >= PB_IN_BASE/4)
              && (int'(word) < PB_IN_BASE/4 + PB_NUM_BANKS);

  always_comb begin
    keep = '1;
    newv = '0;
    if (wr_md) begin
      keep[int'(word)*PB_HALF_W +: PB_HALF_W] = wdata_i[PB_HALF_W +: PB_HALF_W];
      newv[int'(word)*PB_HALF_W +: PB_HALF_W] = wdata_i[PB_HALF_W-1:0];
    end
  end

  p_mask_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_md) |-> ((gpio_o ^ $past(gpio_o)) & $past(keep)) == '0);

  p_mask_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_md) |-> ((gpio_o ^ $past(newv)) & ~$past(keep)) == '0);

  p_ro_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_in) |-> $stable(gpio_o) && $stable(gpio_oe_o));

  p_no_write_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && we_i) |-> $stable(gpio_o) && $stable(gpio_oe_o));

  p_rdata_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> rdata_o == '0);

  p_oe_needs_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|gpio_oe_o) |-> $past(req_i && we_i));
endmodule

bind pin_bank_io pbio_chk u_pbio_chk (.*);

// File: tb/pin_bank_io_tb.sv
`timescale 1ns/1ps
module pin_bank_io_tb_top;
  localparam int NB = 4;
  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NP-1:0] m_lat = '0;
  logic [31:0]   m_dir [NB];
  logic [31:0]   m_oe  [NB];

  always #5 clk = ~clk;

  pin_bank_io dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_i(pin_in), .gpio_o(pin_out),
    .gpio_oe_o(pin_oe)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] v;
    for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_dir[b] & m_oe[b];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w = int'(a[11:2]);
    if (w < 8) return {16'h0, m_lat[w*16 +: 16]};
    for (int b = 0; b < NB; b++) begin
      if (w == ('h060 + 4*b)/4) return pin_in[b*32 +: 32];
      if (w == ('h204 + 'h40*b)/4) return m_dir[b];
      if (w == ('h208 + 'h40*b)/4) return m_oe[b];
    end
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    int w = int'(a[11:2]);
    if (w < 8) begin
      for (int j = 0; j < 16; j++)
        if (!d[16+j]) m_lat[w*16+j] = d[j];
    end
    for (int b = 0; b < NB; b++) begin
      if (w == ('h204 + 'h40*b)/4) m_dir[b] = d;
      if (w == ('h208 + 'h40*b)/4) m_oe[b] = d;
    end
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_write(a, d);
    chk({tag, " gpio_o"}, pin_out, m_lat);
    chk("R6 gpio_oe_o", pin_oe, exp_oe());
    chk("R10 rdata after write", NP'(rdata), '0);
  endtask

  task automatic bus_rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(tag, NP'(rdata), NP'(exp_read(a)));
    @(negedge clk);
    chk("R10 rdata idle", NP'(rdata), '0);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] unm [5];
    unm[0] = 12'h020; unm[1] = 12'h070; unm[2] = 12'h200; unm[3] = 12'h20C; unm[4] = 12'hFFC;
    for (int b = 0; b < NB; b++) begin m_dir[b] = '0; m_oe[b] = '0; end
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk("R1 gpio_o reset", pin_out, '0);
    chk("R1 gpio_oe_o reset", pin_oe, '0);
    chk("R1 rdata reset", NP'(rdata), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: masked writes
    bus_wr(12'h000, 32'h0000_FFFF, "R2 all load");
    bus_wr(12'h000, 32'hFFFE_0000, "R2 single clear");
    bus_wr(12'h01C, 32'h7FFF_8000, "R2 top pin set");
    bus_wr(12'h01C, 32'hFFFF_0000, "R2 all protected");
    bus_rd(12'h000, "R3 half 0 readback");
    bus_rd(12'h01C, "R3 half 7 readback");
    bus_rd(12'h01F, "R11 low addr bits ignored");

    // direction / enable combinations
    bus_wr(12'h204, 32'hFF00_FF00, "R4 dir bank0");
    bus_wr(12'h208, 32'hF0F0_F0F0, "R5 oe bank0");
    bus_wr(12'h2C8, 32'hFFFF_FFFF, "R5 oe bank3 only");
    bus_rd(12'h204, "R4 dir readback");
    bus_rd(12'h2C8, "R5 oe readback");
    bus_wr(12'h2C4, 32'h0000_0001, "R6 bank3 pin 96 driven");

    // read-only / unmapped writes
    bus_wr(12'h060, 32'hFFFF_FFFF, "R8 input reg write");
    for (int i = 0; i < 5; i++) bus_wr(unm[i], 32'h0000_FFFF, "R8 unmapped write");
    for (int i = 0; i < 5; i++) bus_rd(unm[i], "R9 unmapped read");

    // input synchronizer
    set_pins({32'hDEAD_BEEF, 32'h1234_5678, 32'h0, 32'hFFFF_FFFF});
    for (int b = 0; b < NB; b++) bus_rd(12'(12'h060 + 4*b), "R7 input read");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      int b  = $urandom_range(0, NB-1);
      case (op)
        0: bus_wr(12'(4*$urandom_range(0, 7)), $urandom, "R2 random masked");
        1: bus_wr(12'(12'h204 + 'h40*b), $urandom, "R4 random dir");
        2: bus_wr(12'(12'h208 + 'h40*b), $urandom, "R5 random oe");
        3: begin
          set_pins({$urandom, $urandom, $urandom, $urandom});
          bus_rd(12'(12'h060 + 4*b), "R7 random input");
        end
        4: bus_rd(12'(4*$urandom_range(0, 7)), "R3 random readback");
        default: begin
          bus_rd(12'(12'h204 + 'h40*b), "R4 random dir read");
          bus_rd(12'(12'h208 + 'h40*b), "R5 random oe read");
        end
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule